// File: doc/BRIEF.md
# Page Ownership Directory Controller

This block keeps the coherence directory for a set of shared pages spread across a group of nodes under an invalidate-based scheme. For every page it holds a mode (shared-read or exclusive-write), the node that currently owns the page, and a bit-vector of the nodes holding a copy. Nodes send read-miss and write requests. The directory answers by issuing commands to the nodes: downgrade, copy, invalidate and ownership transfer. It collects one acknowledgement per command before it changes the page entry. When the transaction is complete it sends a grant to the requester.

The directory is split into slices. The low bits of the page number select the slice that owns a page. Each slice works on one transaction at a time and has its own outgoing command lane. Slices run independently, so a slow invalidation round in one slice does not hold up another. All messages are valid/ready packets that carry a type, a page number and node IDs. Moving page data and delivering messages over the network are done outside this block.

Top module: `pageDirectory`

## Requirements
- R1: After reset, every page is in write mode, is owned by node 0, and has a copyset that holds only node 0.
- R2: Page p is handled by slice p mod SLICES. Both its requests and its acknowledgements go to that slice, and its commands appear only on that slice's lane.
- R3: A read miss on a write-mode page first sends a downgrade (cmdType 1) to the owner and waits for its ack. The page becomes shared-read. Only then is a copy command (cmdType 2) sent to the owner, with cmdPeer set to the requester.
- R4: A read miss on a shared-read page sends only a copy command to the owner. After its ack, the requester joins the copyset and receives a grant (cmdType 5).
- R5: A read by a node that already holds a copy is granted at once, with no other command.
- R6: A write sends one invalidate (cmdType 3) to each copyset member other than the requester and the owner, in ascending node order. The ack counter starts at the number of those nodes, and nothing else happens until every one of them has acknowledged.
- R7: If the writer is not the owner, the invalidations are followed by a transfer (cmdType 4) to the old owner with cmdPeer set to the writer. After its ack, the page is in write mode, owned by the writer, and the writer is the sole holder.
- R8: A write by the owner receives no transfer. If the owner is the sole holder, the write is granted with no invalidates.
- R9: A slice holds reqReady low from the moment it accepts a request until its grant is taken. Requests to other slices are still accepted during that time.
- R10: An acknowledgement is ignored if it names a node that is not awaited or a page other than the one in progress.
- R11: A command, once valid, keeps its type, page and nodes stable until cmdReady is high. Grants carry the requester in both cmdNode and cmdPeer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Slice of reqPage can accept |
| reqWrite | input | 1 | 1 = write request, 0 = read miss |
| reqPage | input | PAGE_W | Requested page |
| reqNode | input | NODE_W | Requesting node |
| ackValid | input | 1 | Acknowledgement pulse |
| ackPage | input | PAGE_W | Page being acknowledged |
| ackNode | input | NODE_W | Node that acknowledges |
| cmdValid | output | SLICES | Command present, per slice |
| cmdReady | input | SLICES | Command taken, per slice |
| cmdType | output | SLICES x 3 | Command code, per slice |
| cmdPage | output | SLICES x PAGE_W | Page of the command |
| cmdNode | output | SLICES x NODE_W | Node the command is addressed to |
| cmdPeer | output | SLICES x NODE_W | Requesting node the command serves |

## Verification
Some properties hold in every state, and the assertions check these on every cycle. Every write-mode page has exactly its owner in the copyset. The owner of a shared page always holds a copy. The pending-ack counter always equals the number of awaited nodes. Commands hold their fields stable while stalled. No invalidate is ever addressed to the requester. No copy command leaves while the page is still in write mode. The order of the commands, how ownership moves across a sequence of transactions, the dropping of stray acks, and the independence of the slices are shown only by the bench's directed scenarios.

// File: rtl/pageDirPkg.sv
package pageDirPkg;

  typedef enum logic [2:0] {
    MSG_NONE  = 3'd0,
    MSG_DOWN  = 3'd1,
    MSG_COPY  = 3'd2,
    MSG_INV   = 3'd3,
    MSG_XFER  = 3'd4,
    MSG_GRANT = 3'd5
  } msgKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     latch;
    logic     armSingle;
    logic     armInv;
    logic     invSent;
    logic     applyAck;
    logic     upgrade;
    msgKind_e phase;
  } dirStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic isWrite;
    logic isHolder;
    logic isOwner;
    logic modeW;
    logic invNeeded;
    logic lastInv;
    logic acksDone;
  } dirStatus_t;

endpackage

// File: rtl/dirData.sv
module dirData
  import pageDirPkg::*;
#(
  parameter int NODES   = 4,
  parameter int ROWS    = 8,
  parameter int PAGE_W  = 4,
  parameter int NODE_W  = 2,
  parameter int SLICE_W = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dirStrobe_t        stb,
  input  logic              reqWrite,
  input  logic [PAGE_W-1:0] reqPage,
  input  logic [NODE_W-1:0] reqNode,
  input  logic              ackValid,
  input  logic [PAGE_W-1:0] ackPage,
  input  logic [NODE_W-1:0] ackNode,
  output dirStatus_t        st,
  output logic [PAGE_W-1:0] curPageOut,
  output logic [NODE_W-1:0] tgtNode,
  output logic [NODE_W-1:0] peerNode
);

  localparam int ROW_W = PAGE_W - SLICE_W;
  localparam int CNT_W = NODE_W + 1;

  function automatic logic [CNT_W-1:0] popCount(input logic [NODES-1:0] m);
    popCount = '0;
    for (int i = 0; i < NODES; i++) popCount = popCount + CNT_W'(m[i]);
  endfunction

  function automatic logic [NODE_W-1:0] lowestSet(input logic [NODES-1:0] m);
    lowestSet = '0;
    for (int i = NODES - 1; i >= 0; i--) if (m[i]) lowestSet = NODE_W'(i);
  endfunction

  logic              modeW   [ROWS];
  logic [NODE_W-1:0] owner   [ROWS];
  logic [NODES-1:0]  copyset [ROWS];

  logic [PAGE_W-1:0] curPage;
  logic [NODE_W-1:0] curNode;
  logic              curWrite;
  msgKind_e          doneKind;
  logic [NODES-1:0]  ackMask;
  logic [CNT_W-1:0]  ackCount;
  logic [NODES-1:0]  sendMask;

  logic [ROW_W-1:0]  row;
  logic              entMode;
  logic [NODE_W-1:0] entOwner;
  logic [NODES-1:0]  entSet, reqBit, ownBit, invMask;
  logic [NODE_W-1:0] invTarget;
  logic              ackHit;

  always_comb begin
    row       = curPage[PAGE_W-1:SLICE_W];
    entMode   = modeW[row];
    entOwner  = owner[row];
    entSet    = copyset[row];
    reqBit    = NODES'(1) << curNode;
    ownBit    = NODES'(1) << entOwner;
    invMask   = entSet & ~reqBit & ~ownBit;
    invTarget = lowestSet(sendMask);
    ackHit    = ackValid && (ackPage == curPage) && ackMask[ackNode];

    st.isWrite   = curWrite;
    st.isHolder  = |(entSet & reqBit);
    st.isOwner   = (entOwner == curNode);
    st.modeW     = entMode;
    st.invNeeded = |invMask;
    st.lastInv   = ((sendMask & (sendMask - NODES'(1))) == '0);
    st.acksDone  = (ackCount == '0);

    curPageOut = curPage;
    peerNode   = curNode;
    case (stb.phase)
      MSG_INV:   tgtNode = invTarget;
      MSG_GRANT: tgtNode = curNode;
      default:   tgtNode = entOwner;
    endcase
  end

  // transaction registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPage  <= '0;
      curNode  <= '0;
      curWrite <= 1'b0;
      doneKind <= MSG_NONE;
      ackMask  <= '0;
      ackCount <= '0;
      sendMask <= '0;
    end else begin
      if (stb.latch) begin
        curPage  <= reqPage;
        curNode  <= reqNode;
        curWrite <= reqWrite;
      end
      if (stb.armSingle) begin
        ackMask  <= ownBit;
        ackCount <= CNT_W'(1);
        doneKind <= stb.phase;
      end else if (stb.armInv) begin
        ackMask  <= invMask;
        ackCount <= popCount(invMask);
        sendMask <= invMask;
        doneKind <= MSG_INV;
      end else begin
        if (ackHit) begin
          ackMask[ackNode] <= 1'b0;
          ackCount         <= ackCount - CNT_W'(1);
        end
        if (stb.invSent) sendMask <= sendMask & ~(NODES'(1) << invTarget);
      end
    end
  end

  // directory entries
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < ROWS; r++) begin
        modeW[r]   <= 1'b1;
        owner[r]   <= '0;
        copyset[r] <= NODES'(1);
      end
    end else if (stb.applyAck) begin
      case (doneKind)
        MSG_DOWN: modeW[row] <= 1'b0;
        MSG_COPY: copyset[row] <= entSet | reqBit;
        MSG_INV:  copyset[row] <= entSet & ~invMask;
        MSG_XFER: begin
          owner[row]   <= curNode;
          copyset[row] <= reqBit;
          modeW[row]   <= 1'b1;
        end
        default: ;
      endcase
    end else if (stb.upgrade) begin
      modeW[row]   <= 1'b1;
      copyset[row] <= reqBit;
    end
  end

  assert property (@(posedge clk) disable iff (!rstN)
    ackCount == popCount(ackMask))
    else $error("ack counter out of step with awaited nodes");  // assert_ack_count_R6

  for (genvar r = 0; r < ROWS; r++) begin : g_rowChk
    assert_w_single_copy_R7: assert property (@(posedge clk) disable iff (!rstN)
      modeW[r] |-> (copyset[r] == (NODES'(1) << owner[r])))
      else $error("write-mode page has extra copies");
    assert_owner_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
      copyset[r][owner[r]])
      else $error("owner lost its copy");
  end

endmodule

// File: rtl/dirCtrl.sv
module dirCtrl
  import pageDirPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqFire,
  input  logic       cmdReady,
  input  dirStatus_t st,
  output dirStrobe_t stb,
  output logic       idle,
  output logic       cmdValid,
  output logic [2:0] cmdType
);

  typedef enum logic [2:0] {ST_IDLE, ST_DECIDE, ST_SEND, ST_WAIT, ST_GRANT} state_e;

  state_e   state, stateNext;
  msgKind_e kindReg, kindNext;

  always_comb begin
    stb       = '0;
    stateNext = state;
    kindNext  = kindReg;
    idle      = 1'b0;
    cmdValid  = 1'b0;
    case (state)
      ST_IDLE: begin
        idle = 1'b1;
        if (reqFire) begin
          stb.latch = 1'b1;
          stateNext = ST_DECIDE;
        end
      end
      ST_DECIDE: begin
        if (!st.isWrite) begin
          if (st.isHolder) begin
            kindNext  = MSG_GRANT;
            stateNext = ST_GRANT;
          end else begin
            kindNext      = st.modeW ? MSG_DOWN : MSG_COPY;
            stb.armSingle = 1'b1;
            stateNext     = ST_SEND;
          end
        end else if (st.invNeeded) begin
          kindNext   = MSG_INV;
          stb.armInv = 1'b1;
          stateNext  = ST_SEND;
        end else if (!st.isOwner) begin
          kindNext      = MSG_XFER;
          stb.armSingle = 1'b1;
          stateNext     = ST_SEND;
        end else begin
          stb.upgrade = 1'b1;
          kindNext    = MSG_GRANT;
          stateNext   = ST_GRANT;
        end
      end
      ST_SEND: begin
        cmdValid = 1'b1;
        if (cmdReady) begin
          if (kindReg == MSG_INV) begin
            stb.invSent = 1'b1;
            if (st.lastInv) stateNext = ST_WAIT;
          end else begin
            stateNext = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (st.acksDone) begin
          stb.applyAck = 1'b1;
          stateNext    = ST_DECIDE;
        end
      end
      ST_GRANT: begin
        cmdValid = 1'b1;
        if (cmdReady) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
    stb.phase = (state == ST_DECIDE) ? kindNext : kindReg;
    cmdType   = kindReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      kindReg <= MSG_NONE;
    end else begin
      state   <= stateNext;
      kindReg <= kindNext;
    end
  end

  assert_copy_after_down_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEND && kindReg == MSG_COPY) |-> !st.modeW)
    else $error("copy issued while page still in write mode");

endmodule

// File: rtl/pageDirectory.sv
module pageDirectory
  import pageDirPkg::*;
#(
  parameter  int NODES   = 4,
  parameter  int PAGES   = 16,
  parameter  int SLICES  = 2,
  localparam int NODE_W  = $clog2(NODES),
  localparam int PAGE_W  = $clog2(PAGES),
  localparam int SLICE_W = $clog2(SLICES),
  localparam int ROWS    = PAGES / SLICES
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           reqValid,
  output logic                           reqReady,
  input  logic                           reqWrite,
  input  logic [PAGE_W-1:0]              reqPage,
  input  logic [NODE_W-1:0]              reqNode,
  input  logic                           ackValid,
  input  logic [PAGE_W-1:0]              ackPage,
  input  logic [NODE_W-1:0]              ackNode,
  output logic [SLICES-1:0]              cmdValid,
  input  logic [SLICES-1:0]              cmdReady,
  output logic [SLICES-1:0][2:0]         cmdType,
  output logic [SLICES-1:0][PAGE_W-1:0]  cmdPage,
  output logic [SLICES-1:0][NODE_W-1:0]  cmdNode,
  output logic [SLICES-1:0][NODE_W-1:0]  cmdPeer
);

  logic [SLICES-1:0] sliceIdle;

  assign reqReady = sliceIdle[reqPage[SLICE_W-1:0]];

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    dirStrobe_t stb;
    dirStatus_t st;
    logic       reqFire, ackHere;

    assign reqFire = reqValid && (reqPage[SLICE_W-1:0] == SLICE_W'(s)) && sliceIdle[s];
    assign ackHere = ackValid && (ackPage[SLICE_W-1:0] == SLICE_W'(s));

    dirCtrl i_ctrl (
      .clk      (clk),
      .rstN     (rstN),
      .reqFire  (reqFire),
      .cmdReady (cmdReady[s]),
      .st       (st),
      .stb      (stb),
      .idle     (sliceIdle[s]),
      .cmdValid (cmdValid[s]),
      .cmdType  (cmdType[s])
    );

    dirData #(
      .NODES   (NODES),
      .ROWS    (ROWS),
      .PAGE_W  (PAGE_W),
      .NODE_W  (NODE_W),
      .SLICE_W (SLICE_W)
    ) i_data (
      .clk        (clk),
      .rstN       (rstN),
      .stb        (stb),
      .reqWrite   (reqWrite),
      .reqPage    (reqPage),
      .reqNode    (reqNode),
      .ackValid   (ackHere),
      .ackPage    (ackPage),
      .ackNode    (ackNode),
      .st         (st),
      .curPageOut (cmdPage[s]),
      .tgtNode    (cmdNode[s]),
      .peerNode   (cmdPeer[s])
    );

    assert_cmd_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
      (cmdValid[s] && !cmdReady[s]) |=> (cmdValid[s] && $stable(cmdType[s]) &&
        $stable(cmdPage[s]) && $stable(cmdNode[s]) && $stable(cmdPeer[s])))
      else $error("command changed while stalled");

    assert_inv_not_requester_R6: assert property (@(posedge clk) disable iff (!rstN)
      (cmdValid[s] && cmdType[s] == 3'(MSG_INV)) |-> (cmdNode[s] != cmdPeer[s]))
      else $error("invalidate sent to requester");

    assert_page_in_slice_R2: assert property (@(posedge clk) disable iff (!rstN)
      cmdValid[s] |-> (cmdPage[s][SLICE_W-1:0] == SLICE_W'(s)))
      else $error("command for foreign page on slice lane");
  end

endmodule

// File: tb/test_pageDirectory.sv
`timescale 1ns/1ps
module test_pageDirectory;

  localparam int NODES = 4, PAGES = 16, SLICES = 2;
  localparam int DOWN = 1, COPY = 2, INV = 3, XFER = 4, GRANT = 5;

  logic                  clk = 1'b0;
  logic                  rstN = 1'b0;
  logic                  reqValid = 1'b0;
  logic                  reqReady;
  logic                  reqWrite = 1'b0;
  logic [3:0]            reqPage = '0;
  logic [1:0]            reqNode = '0;
  logic                  ackValid = 1'b0;
  logic [3:0]            ackPage = '0;
  logic [1:0]            ackNode = '0;
  logic [1:0]            cmdValid;
  logic [1:0]            cmdReady = '0;
  logic [1:0][2:0]       cmdType;
  logic [1:0][3:0]       cmdPage;
  logic [1:0][1:0]       cmdNode;
  logic [1:0][1:0]       cmdPeer;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pageDirectory #(.NODES(NODES), .PAGES(PAGES), .SLICES(SLICES)) i_pageDirectory (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqPage(reqPage), .reqNode(reqNode),
    .ackValid(ackValid), .ackPage(ackPage), .ackNode(ackNode),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdType(cmdType),
    .cmdPage(cmdPage), .cmdNode(cmdNode), .cmdPeer(cmdPeer)
  );

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %s expected %s", tag, act, exp);
    end
  endtask

  task automatic doReq(input bit wr, input int page, input int node);
    reqWrite = wr; reqPage = 4'(page); reqNode = 2'(node); reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic expectCmd(input int s, input int kind, input int page, input int node,
                           input int peer, input string tag);
    int n = 0;
    while (!cmdValid[s] && n < 40) begin @(negedge clk); n++; end
    check(cmdValid[s] && cmdType[s] == 3'(kind) && cmdPage[s] == 4'(page) &&
          cmdNode[s] == 2'(node) && cmdPeer[s] == 2'(peer) && !cmdValid[1-s], tag,
          $sformatf("v=%0b type=%0d page=%0d node=%0d peer=%0d other=%0b", cmdValid[s],
                    cmdType[s], cmdPage[s], cmdNode[s], cmdPeer[s], cmdValid[1-s]),
          $sformatf("v=1 type=%0d page=%0d node=%0d peer=%0d other=0", kind, page, node, peer));
    cmdReady[s] = 1'b1;
    @(negedge clk);
    cmdReady[s] = 1'b0;
  endtask

  task automatic sendAck(input int page, input int node);
    ackValid = 1'b1; ackPage = 4'(page); ackNode = 2'(node);
    @(negedge clk);
    ackValid = 1'b0;
  endtask

  task automatic expectQuiet(input int s, input int cycles, input string tag);
    repeat (cycles) @(negedge clk);
    check(cmdValid[s] == 1'b0, tag, $sformatf("cmdValid=%0b", cmdValid[s]), "cmdValid=0");
  endtask

  task automatic testReset;
    check(reqReady == 1'b1 && cmdValid == 2'b00, "R1 reset idle",
          $sformatf("ready=%0b valid=%0b", reqReady, cmdValid), "ready=1 valid=00");
    doReq(1, 2, 0);
    expectCmd(0, GRANT, 2, 0, 0, "R1 R8 owner node 0 write grant");
  endtask

  task automatic testReadFromWrite;
    doReq(0, 3, 1);
    expectCmd(1, DOWN, 3, 0, 1, "R3 R2 downgrade to owner on odd slice");
    expectQuiet(1, 3, "R3 copy held until downgrade ack");
    sendAck(3, 0);
    expectCmd(1, COPY, 3, 0, 1, "R3 copy after downgrade");
    sendAck(3, 0);
    expectCmd(1, GRANT, 3, 1, 1, "R3 grant reader");
  endtask

  task automatic testReadShared;
    doReq(0, 3, 2);
    expectCmd(1, COPY, 3, 0, 2, "R4 copy only on shared page");
    sendAck(3, 0);
    expectCmd(1, GRANT, 3, 2, 2, "R4 grant");
    doReq(0, 3, 1);
    expectCmd(1, GRANT, 3, 1, 1, "R5 holder read granted directly");
  endtask

  task automatic testWriteInvalidate;
    doReq(1, 3, 3);
    expectCmd(1, INV, 3, 1, 3, "R6 first invalidate lowest node");
    expectCmd(1, INV, 3, 2, 3, "R6 second invalidate");
    sendAck(3, 3);
    sendAck(5, 2);
    expectQuiet(1, 4, "R10 stray acks ignored");
    // R9 busy slice stalls, other slice still served
    reqValid = 1'b1; reqWrite = 1'b0; reqPage = 4'd5; reqNode = 2'd1;
    #1;
    check(reqReady == 1'b0, "R9 busy slice stalls", $sformatf("%0b", reqReady), "0");
    reqWrite = 1'b1; reqPage = 4'd4; reqNode = 2'd0;
    #1;
    check(reqReady == 1'b1, "R9 idle slice ready", $sformatf("%0b", reqReady), "1");
    @(negedge clk);
    reqValid = 1'b0;
    expectCmd(0, GRANT, 4, 0, 0, "R9 R2 other slice grant during wait");
    sendAck(3, 1);
    expectQuiet(1, 2, "R6 waits for all acks");
    sendAck(3, 2);
    expectCmd(1, XFER, 3, 0, 3, "R7 transfer to old owner");
    sendAck(3, 0);
    expectCmd(1, GRANT, 3, 3, 3, "R7 grant writer");
  endtask

  task automatic testOwnership;
    doReq(0, 3, 3);
    expectCmd(1, GRANT, 3, 3, 3, "R7 writer holds copy");
    doReq(1, 3, 3);
    expectCmd(1, GRANT, 3, 3, 3, "R8 sole owner write no invalidate");
    doReq(0, 3, 0);
    expectCmd(1, DOWN, 3, 3, 0, "R7 new owner downgraded");
    sendAck(3, 3);
    expectCmd(1, COPY, 3, 3, 0, "R3 copy from new owner");
    sendAck(3, 3);
    expectCmd(1, GRANT, 3, 0, 0, "R4 grant node0");
    doReq(1, 3, 3);
    expectCmd(1, INV, 3, 0, 3, "R8 owner write invalidates other holder");
    sendAck(3, 0);
    expectCmd(1, GRANT, 3, 3, 3, "R8 owner write no transfer");
  endtask

  task automatic testHolderWrite;
    doReq(0, 3, 1);
    expectCmd(1, DOWN, 3, 3, 1, "R3 downgrade");
    sendAck(3, 3);
    expectCmd(1, COPY, 3, 3, 1, "R3 copy");
    sendAck(3, 3);
    expectCmd(1, GRANT, 3, 1, 1, "R4 grant");
    doReq(1, 3, 1);
    expectCmd(1, XFER, 3, 3, 1, "R7 holder writer gets transfer only");
    sendAck(3, 3);
    expectCmd(1, GRANT, 3, 1, 1, "R7 grant");
    doReq(1, 3, 1);
    expectCmd(1, GRANT, 3, 1, 1, "R8 new sole owner write");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", checks - errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testReadFromWrite();
    testReadShared();
    testWriteInvalidate();
    testOwnership();
    testHolderWrite();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - errors, checks);
    $finish;
  end

endmodule